// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a serial stereo audio stream into parallel samples. A frame clock separates each frame into a left half and a right half. Words are two's complement and arrive MSB first, one bit per bit-clock cycle. The bit clock comes either from a pin or from a divider on the master clock. For the divider, the block measures the master-clock to frame-clock ratio and derives a bit clock of 32, 48 or 64 cycles per frame.

Two static selectors, changed only while reset is asserted, set the framing and the word length. The framing is delayed-by-one (I2S), left-justified or right-justified. The word length is 16, 18, 20 or 24 bits. Each received word is sign-extended to 24 bits. After each right word completes, the left and right samples are presented together with a one-cycle valid strobe. Everything runs in the master-clock domain. The frame clock, the external bit clock and the data line are sampled through one register stage.

Top module: `serial_audio_rx`

## Requirements
- R1: While rst_ni is low, left_o and right_o are zero and valid_o is low.
- R2: With fmt_i = 0 (I2S), the MSB is in the second bit cell after a frame-clock change, and the left word is the one sent while lrclk_i is low. A 16-bit word in a 16-cell half has its LSB in the first cell of the next half.
- R3: With fmt_i = 1 (left-justified), the MSB is in the first bit cell after a frame-clock change, and the left word is the one sent while lrclk_i is high. fmt_i = 3 behaves the same way.
- R4: With fmt_i = 2 (right-justified), the LSB is the last bit cell before a frame-clock change, and the left word is the one sent while lrclk_i is high.
- R5: width_i selects the word length: 0 = 16, 1 = 18, 2 = 20, 3 = 24 bits. Each word is sign-extended to 24 bits, so the most positive and most negative codes map to their 24-bit equivalents.
- R6: valid_o is a single-cycle pulse, once per frame, after the right word completes. left_o and right_o change only in the cycle valid_o is high.
- R7: With ext_bclk_sel_i = 1, data is sampled on each rising edge of bclk_i, and every valid_o follows a sampled bit by one cycle.
- R8: In internal mode, the ratio is the number of clk_i cycles between rising edges of lrclk_i. Only 128, 192, 256, 384 and 512 are accepted. With any other ratio, bclk_o stays low and no sample is produced. The accepted ratio changes only on a rising frame-clock edge.
- R9: The internal bit clock runs at 48 cells per frame for ratios 192 and 384. For the other ratios it runs at 32 cells per frame when width_i = 0 and the framing is I2S or right-justified, and at 64 cells per frame otherwise. Its divisor is ratio / cells, with a 50% duty cycle. It restarts low on every frame-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_bclk_sel_i | input | 1 | 1: sample on bclk_i; 0: use the internal divider |
| fmt_i | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 as 1 |
| width_i | input | 2 | Word length code: 16/18/20/24 bits |
| bclk_i | input | 1 | External bit clock |
| lrclk_i | input | 1 | Frame clock selecting the channel |
| sdata_i | input | 1 | Serial data, MSB first |
| bclk_o | output | 1 | Internally generated bit clock |
| left_o | output | 24 | Left sample, sign-extended |
| right_o | output | 24 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe when both samples update |

## Verification
The bench sweeps every framing against every word length, in both internal and external bit-clock modes, and covers all five accepted ratios. Each frame carries either the extreme codes (most positive left, most negative right) or mixed bit patterns. The extreme codes expose sign-extension and bit-offset errors. The mixed patterns catch bit-order and channel swaps. Counting internal bit-clock rises per frame separates the 32/48/64 rate choices, including the 16-bit I2S case whose LSB spills into the next half. An unsupported ratio checks that the divider stays silent.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_ALT = 2'd3
  } fmt_e;

  function automatic int unsigned word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/sarx_ratio_det.sv
module sarx_ratio_det #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lrck_rise_i,
  output logic             ratio_ok_o,
  output logic [CNT_W-1:0] ratio_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;
  logic             hit;

  always_comb begin
    hit = (cnt_q == CNT_W'(128)) || (cnt_q == CNT_W'(192)) || (cnt_q == CNT_W'(256)) ||
          (cnt_q == CNT_W'(384)) || (cnt_q == CNT_W'(512));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      seen_q     <= 1'b0;
      ratio_ok_o <= 1'b0;
      ratio_o    <= '0;
    end else if (lrck_rise_i) begin
      cnt_q      <= CNT_W'(1);
      seen_q     <= 1'b1;
      ratio_ok_o <= seen_q && hit;
      ratio_o    <= (seen_q && hit) ? cnt_q : '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sarx_bclk_gen.sv
module sarx_bclk_gen import sarx_pkg::*; #(
  parameter int CNT_W = 10,
  parameter int DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ratio_ok_i,
  input  logic [CNT_W-1:0] ratio_i,
  input  logic [1:0]       fmt_i,
  input  logic [1:0]       width_i,
  input  logic             lrck_edge_i,
  output logic             bclk_o,
  output logic             bit_evt_o
);
  logic [DIV_W-1:0] div_q, n_w, half_w;
  logic             tri_rate, narrow;

  always_comb begin
    tri_rate = (ratio_i == CNT_W'(192)) || (ratio_i == CNT_W'(384));
    narrow   = (width_i == 2'd0) && ((fmt_i == FMT_I2S) || (fmt_i == FMT_RJ));
    if (tri_rate)    n_w = (ratio_i == CNT_W'(192)) ? DIV_W'(4) : DIV_W'(8);
    else if (narrow) n_w = DIV_W'(ratio_i >> 5);
    else             n_w = DIV_W'(ratio_i >> 6);
    half_w    = n_w >> 1;
    bclk_o    = ratio_ok_i && (div_q >= half_w);
    bit_evt_o = ratio_ok_i && (div_q == half_w - DIV_W'(1));
  end

  // divider restarts on every frame-clock edge to stay phase-aligned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else if (!ratio_ok_i || lrck_edge_i || (div_q == n_w - DIV_W'(1))) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/sarx_deframer.sv
module sarx_deframer import sarx_pkg::*; #(
  parameter int DATA_W = 24,
  parameter int IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_evt_i,
  input  logic              bit_i,
  input  logic              lrck_i,
  input  logic [1:0]        fmt_i,
  input  logic [1:0]        width_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o
);
  localparam int SH_W = $clog2(DATA_W + 1);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [DATA_W-1:0]        sr_q, sr_nx, raw, hold_q;
  logic [IDX_W-1:0]         idx_q, pos, wlen;
  logic                     half_q, primed_q, synced_q;
  logic                     boundary, cap, use_nx, is_left;
  logic [SH_W-1:0]          sh;
  logic signed [DATA_W-1:0] aligned, word;

  always_comb begin
    wlen     = IDX_W'(word_bits(width_i));
    sh       = SH_W'(DATA_W) - SH_W'(word_bits(width_i));
    boundary = primed_q && (lrck_i != half_q);
    pos      = boundary ? '0 : ((idx_q == IDX_MAX) ? idx_q : idx_q + 1'b1);
    sr_nx    = {sr_q[DATA_W-2:0], bit_i};
    case (fmt_i)
      FMT_I2S: begin
        // LSB may land on the first cell of the following half
        use_nx = 1'b1;
        cap    = synced_q && (boundary ? (idx_q + 1'b1 == wlen) : (pos == wlen));
      end
      FMT_RJ: begin
        use_nx = 1'b0;
        cap    = synced_q && boundary;
      end
      default: begin
        use_nx = 1'b1;
        cap    = synced_q && !boundary && (pos == wlen - 1'b1);
      end
    endcase
    raw     = use_nx ? sr_nx : sr_q;
    aligned = $signed(raw << sh);
    word    = aligned >>> sh;
    is_left = (fmt_i == FMT_I2S) ? !half_q : half_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      idx_q    <= '0;
      half_q   <= 1'b0;
      primed_q <= 1'b0;
      synced_q <= 1'b0;
      hold_q   <= '0;
      left_o   <= '0;
      right_o  <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (bit_evt_i) begin
        sr_q  <= sr_nx;
        idx_q <= pos;
        if (!primed_q) begin
          primed_q <= 1'b1;
          half_q   <= lrck_i;
        end else if (boundary) begin
          half_q   <= lrck_i;
          synced_q <= 1'b1;
        end
        if (cap) begin
          if (is_left) begin
            hold_q <= word;
          end else begin
            left_o  <= hold_q;
            right_o <= word;
            valid_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx import sarx_pkg::*; #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 10,
  parameter int DIV_W  = 5,
  parameter int IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_bclk_sel_i,
  input  logic [1:0]        fmt_i,
  input  logic [1:0]        width_i,
  input  logic              bclk_i,
  input  logic              lrclk_i,
  input  logic              sdata_i,
  output logic              bclk_o,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o
);
  logic             bclk_q, bclk_p, lrck_q, lrck_d, sd_q;
  logic             lrck_edge, lrck_rise, ext_evt, int_evt, bit_evt;
  logic             ratio_ok;
  logic [CNT_W-1:0] ratio;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      bclk_p <= 1'b0;
      lrck_q <= 1'b0;
      lrck_d <= 1'b0;
      sd_q   <= 1'b0;
    end else begin
      bclk_q <= bclk_i;
      bclk_p <= bclk_q;
      lrck_q <= lrclk_i;
      lrck_d <= lrck_q;
      sd_q   <= sdata_i;
    end
  end

  always_comb begin
    lrck_edge = lrck_q ^ lrck_d;
    lrck_rise = lrck_q & ~lrck_d;
    ext_evt   = bclk_q & ~bclk_p;
    bit_evt   = ext_bclk_sel_i ? ext_evt : int_evt;
  end

  sarx_ratio_det #(.CNT_W(CNT_W)) u_ratio (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lrck_rise_i(lrck_rise),
    .ratio_ok_o (ratio_ok),
    .ratio_o    (ratio)
  );

  sarx_bclk_gen #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_bclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ratio_ok_i (ratio_ok),
    .ratio_i    (ratio),
    .fmt_i      (fmt_i),
    .width_i    (width_i),
    .lrck_edge_i(lrck_edge),
    .bclk_o     (bclk_o),
    .bit_evt_o  (int_evt)
  );

  sarx_deframer #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_deframe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_evt_i(bit_evt),
    .bit_i    (sd_q),
    .lrck_i   (lrck_q),
    .fmt_i    (fmt_i),
    .width_i  (width_i),
    .left_o   (left_o),
    .right_o  (right_o),
    .valid_o  (valid_o)
  );
endmodule

// File: rtl/sarx_checker.sv
module sarx_checker #(
  parameter int DATA_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] left_i,
  input logic [DATA_W-1:0] right_i,
  input logic              bclk_i,
  input logic              lrck_edge_i,
  input logic              lrck_rise_i,
  input logic              bit_evt_i,
  input logic              ratio_ok_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (!valid_i && left_i == '0 && right_i == '0)
        else $error("reset state violated");
    end
  end

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  p_hold_samples_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ($stable(left_i) && $stable(right_i)));

  p_valid_after_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(bit_evt_i));

  p_ratio_update_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ratio_ok_i) |-> $past(lrck_rise_i));

  p_bclk_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lrck_edge_i |=> !bclk_i);
endmodule

bind serial_audio_rx sarx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_o),
  .left_i     (left_o),
  .right_i    (right_o),
  .bclk_i     (bclk_o),
  .lrck_edge_i(lrck_edge),
  .lrck_rise_i(lrck_rise),
  .bit_evt_i  (bit_evt),
  .ratio_ok_i (ratio_ok)
);

// File: tb/serial_audio_rx_tb_top.sv
module serial_audio_rx_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        ext_sel = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic [1:0]  wcode = 2'd0;
  logic        bclk_in = 1'b0;
  logic        lrclk = 1'b0;
  logic        sdata = 1'b0;
  logic        bclk_out, valid;
  logic [23:0] left, right;

  always #5 clk_i = ~clk_i;

  serial_audio_rx dut_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ext_bclk_sel_i(ext_sel),
    .fmt_i         (fmt),
    .width_i       (wcode),
    .bclk_i        (bclk_in),
    .lrclk_i       (lrclk),
    .sdata_i       (sdata),
    .bclk_o        (bclk_out),
    .left_o        (left),
    .right_o       (right),
    .valid_o       (valid)
  );

  int n_chk = 0, n_fail = 0;
  logic [23:0] exp_l[$], exp_r[$];
  logic [23:0] el, er;
  bit armed = 0, prev_valid = 0, prev_bclk = 0, carry = 0;
  int valid_cnt = 0, rise_cnt = 0;
  int cfg_w, cfg_h, cfg_cell;
  bit cfg_ext;
  int unsigned seed = 32'h1234_5678;
  string tag;

  function automatic logic [23:0] sx(input int unsigned raw, input int w);
    int v;
    v = raw[w-1] ? int'(raw) - (1 << w) : int'(raw);
    return v[23:0];
  endfunction

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 4;
  endfunction

  // output monitor, sampled away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (valid) begin
        valid_cnt++;
        if (prev_valid) begin
          n_chk++; n_fail++;
          $display("FAIL R6: valid_o high two cycles, actual 1 expected 0");
        end
        if (armed) begin
          n_chk++;
          if (exp_l.size() == 0) begin
            n_fail++;
            $display("FAIL R6: unexpected valid_o, actual 1 expected 0");
          end else begin
            el = exp_l.pop_front();
            er = exp_r.pop_front();
            if (left !== el || right !== er) begin
              n_fail++;
              $display("FAIL %s: left %h right %h, expected %h %h", tag, left, right, el, er);
            end
          end
        end
      end
      if (bclk_out && !prev_bclk) rise_cnt++;
    end
    prev_valid = valid;
    prev_bclk  = bclk_out;
  end

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    n_chk++;
    if (valid !== 1'b0 || left !== 24'd0 || right !== 24'd0) begin
      n_fail++;
      $display("FAIL R1: reset outputs %b %h %h, expected 0 0 0", valid, left, right);
    end
    rst_ni = 1'b1;
  endtask

  // mode 0 warmup, 1 checked, 2 trailing
  task automatic send_frame(input int mode, input int unsigned rl, input int unsigned rr);
    bit c[64];
    int pl, pr;
    bit lv0;
    for (int i = 0; i < 64; i++) c[i] = 1'b0;
    c[0] = carry;
    carry = 1'b0;
    for (int k = 0; k < cfg_w; k++) begin
      case (fmt)
        2'd0:    begin pl = 1 + k;             pr = cfg_h + 1 + k; end
        2'd2:    begin pl = cfg_h - cfg_w + k; pr = 2 * cfg_h - cfg_w + k; end
        default: begin pl = k;                 pr = cfg_h + k; end
      endcase
      c[pl] = rl[cfg_w-1-k];
      if (pr == 2 * cfg_h) carry = rr[cfg_w-1-k];
      else c[pr] = rr[cfg_w-1-k];
    end
    lv0 = (fmt == 2'd0) ? 1'b0 : 1'b1;
    for (int i = 0; i < 2 * cfg_h; i++) begin
      if (i == cfg_h) begin
        if (mode == 1) begin
          exp_l.push_back(sx(rl, cfg_w));
          exp_r.push_back(sx(rr, cfg_w));
          armed = 1'b1;
        end else if (mode == 2) begin
          n_chk++;
          if (exp_l.size() != 0) begin
            n_fail++;
            $display("FAIL R6: %0d frames without valid_o, expected 0", exp_l.size());
          end
          armed = 1'b0;
        end
      end
      @(negedge clk_i);
      lrclk = (i < cfg_h) ? lv0 : !lv0;
      sdata = c[i];
      if (cfg_ext) begin
        bclk_in = 1'b0;
        repeat (3) @(negedge clk_i);
        bclk_in = 1'b1;
        repeat (2) @(negedge clk_i);
      end else begin
        repeat (cfg_cell - 1) @(negedge clk_i);
      end
    end
  endtask

  task automatic run_cfg(input bit ext, input int f, input int wc, input int ratio);
    int bpf, rises;
    int unsigned mask;
    ext_sel = ext; fmt = 2'(f); wcode = 2'(wc); cfg_ext = ext;
    cfg_w = (wc == 0) ? 16 : (wc == 1) ? 18 : (wc == 2) ? 20 : 24;
    mask = (1 << cfg_w) - 1;
    if (ext) begin
      bpf = 48; cfg_cell = 6;
    end else begin
      if (ratio == 192 || ratio == 384) bpf = 48;
      else if (wc == 0 && f != 1) bpf = 32;
      else bpf = 64;
      cfg_cell = ratio / bpf;
    end
    cfg_h = bpf / 2;
    exp_l.delete(); exp_r.delete();
    armed = 1'b0; carry = 1'b0;
    do_reset();
    case (f)
      0: tag = "R2 R5";
      1: tag = "R3 R5";
      default: tag = "R4 R5";
    endcase
    if (ext) tag = {tag, " R7"};
    for (int k = 0; k < 3; k++) send_frame(0, rnd() & mask, rnd() & mask);
    rise_cnt = 0;
    send_frame(1, (1 << (cfg_w - 1)) - 1, 1 << (cfg_w - 1));
    send_frame(1, 32'hA5C3E1 & mask, 32'h3C5A96 & mask);
    send_frame(1, rnd() & mask, rnd() & mask);
    rises = rise_cnt;
    if (!ext) begin
      n_chk++;
      if (rises != 3 * bpf) begin
        n_fail++;
        $display("FAIL R8 R9: bclk_o rises %0d, expected %0d (ratio %0d)", rises, 3 * bpf, ratio);
      end
    end
    send_frame(2, 0, 0);
  endtask

  initial begin
    #2 rst_ni = 1'b0;
    #20;
    // R8: unsupported ratio of 160 keeps the divider silent
    ext_sel = 1'b0; fmt = 2'd1; wcode = 2'd3;
    do_reset();
    valid_cnt = 0; rise_cnt = 0;
    for (int p = 0; p < 10; p++) begin
      @(negedge clk_i);
      lrclk = ~lrclk;
      for (int j = 0; j < 80; j++) begin
        sdata = rnd() & 1;
        if (j != 79) @(negedge clk_i);
      end
    end
    n_chk++;
    if (valid_cnt != 0 || rise_cnt != 0) begin
      n_fail++;
      $display("FAIL R8: valids %0d rises %0d, expected 0 0", valid_cnt, rise_cnt);
    end
    for (int f = 0; f < 3; f++)
      for (int wc = 0; wc < 4; wc++) begin
        run_cfg(1'b0, f, wc, 128);
        run_cfg(1'b0, f, wc, 192);
      end
    for (int f = 0; f < 3; f++)
      for (int wi = 0; wi < 2; wi++) begin
        run_cfg(1'b0, f, wi * 3, 256);
        run_cfg(1'b0, f, wi * 3, 384);
        run_cfg(1'b0, f, wi * 3, 512);
      end
    for (int f = 0; f < 3; f++)
      for (int wc = 0; wc < 4; wc++) run_cfg(1'b1, f, wc, 0);
    // R3: code 3 behaves as left-justified
    tag = "R3";
    run_cfg(1'b0, 3, 2, 256);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1900000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule